// File: doc/BRIEF.md
# Operand Select Stage

This block is the operand-fetch stage of a small 16-bit pipelined processor. Each cycle the stage is enabled, it captures three operand registers for the execute stage. The A operand is either the A-side register-file value or the result of the instruction one ahead in the pipe. The B operand is either the B-side register-file value or an immediate built from instruction-register fields. The store-data register holds the register value that a store writes to memory.

A two-step immediate is supported. A prefix instruction writes a 12-bit constant into the upper part of B. The instruction that follows it supplies the low 4 bits. The decoder drives a 2-bit B source selector, a store flag and the register indices. The stage itself makes the forwarding decision and tracks whether a prefix is pending.

A low stage enable stalls the whole stage. A synchronous reset clears it.

Top module: `operand_select_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `aOperand`, `bOperand`, `storeData` and `prefixPending` become zero.
- R2: At an edge with `stageEn` low, all outputs keep their values. This includes `prefixPending`.
- R3: At an enabled edge with a non-prefix selector and no forwarding condition, `aOperand` loads `aRegVal`.
- R4: At an enabled edge with a non-prefix selector, `prevWrites` high and `prevDestIdx == srcAIdx`, `aOperand` loads `aluResult`. When `prevWrites` is low, no forwarding occurs.
- R5: When no prefix is pending, `bSel = 0` loads `bRegVal` into `bOperand`.
- R6: When no prefix is pending, `bSel = 1` loads `{12'b0, instr[3:0]}`. `bSel = 2` loads `instr[3]` replicated twelve times above `instr[3:0]`.
- R7: `bSel = 3` is the prefix. It loads `instr[11:0]` into `bOperand[15:4]`. `bOperand[3:0]` and `aOperand` hold, and `prefixPending` is set.
- R8: At an enabled edge with a prefix pending and `bSel != 3`, `bOperand[3:0]` loads `instr[3:0]` and `bOperand[15:4]` holds, whatever `bSel` is. `prefixPending` clears.
- R9: At an enabled edge with `isStore` high, `storeData` loads `bRegVal`. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stageEn | input | 1 | Stage enable; low stalls |
| instr | input | 16 | Instruction register |
| bSel | input | 2 | B source: 0 reg, 1 zero-ext, 2 sign-ext, 3 prefix |
| isStore | input | 1 | Current instruction is a store |
| srcAIdx | input | 4 | A source register index |
| prevDestIdx | input | 4 | Destination index of previous instruction |
| prevWrites | input | 1 | Previous instruction writes a register |
| aRegVal | input | 16 | A-side register-file read data |
| bRegVal | input | 16 | B-side register-file read data |
| aluResult | input | 16 | Previous instruction's ALU result |
| aOperand | output | 16 | A operand register |
| bOperand | output | 16 | B operand register |
| storeData | output | 16 | Store-data register |
| prefixPending | output | 1 | A prefix has loaded B[15:4] and awaits its low part |

## Verification
The bench builds the stage with its default 16-bit data, 4-bit immediate and 4-bit register index. The 16-register index space lets random source and destination indices, drawn from a narrow range, hit the forwarding match often. The 4-bit immediate makes the sign bit of the short immediate toggle on about half of the random instructions. With a 12-bit prefix, every random prefix value reaches the upper B bits unchanged. Directed sequences cover a stall between a prefix and its follower, and two prefixes in a row.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_ZEXT = 2'd1,
    SRC_SEXT = 2'd2,
    SRC_PFX  = 2'd3
  } bSrcT;

  typedef struct packed {
    logic loadA;
    logic useFwd;
    logic loadHi;
    bSrcT hiSrc;
    logic loadLo;
    logic loImm;
    logic loadSt;
  } strobeT;
endpackage

// File: rtl/opsel_ctrl.sv
module opsel_ctrl
  import opsel_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stageEn,
  input  logic [1:0]       bSel,
  input  logic             isStore,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] prevDestIdx,
  input  logic             prevWrites,
  output strobeT           strobe,
  output logic             pending
);
  bSrcT sel;
  logic isPfx;

  always_comb begin
    sel   = bSrcT'(bSel);
    isPfx = (sel == SRC_PFX);
    strobe.loadA  = stageEn && !isPfx;
    strobe.useFwd = prevWrites && (prevDestIdx == srcAIdx);
    // upper bits stay frozen while a prefix waits for its low part
    strobe.loadHi = stageEn && (isPfx || !pending);
    strobe.hiSrc  = sel;
    strobe.loadLo = stageEn && !isPfx;
    strobe.loImm  = pending || (sel != SRC_REG);
    strobe.loadSt = stageEn && isStore;
  end

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (stageEn) pending <= isPfx;
  end
endmodule

// File: rtl/opsel_datapath.sv
module opsel_datapath
  import opsel_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IMM_LO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] aRegVal,
  input  logic [DATA_W-1:0] bRegVal,
  input  logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] aOperand,
  output logic [DATA_W-1:0] bOperand,
  output logic [DATA_W-1:0] storeData
);
  localparam int HI_W = DATA_W - IMM_LO_W;

  logic [DATA_W-1:0]   fwdVal;
  logic [HI_W-1:0]     hiNext;
  logic [IMM_LO_W-1:0] loNext;

  always_comb begin
    fwdVal = strobe.useFwd ? aluResult : aRegVal;
    unique case (strobe.hiSrc)
      SRC_REG:  hiNext = bRegVal[DATA_W-1:IMM_LO_W];
      SRC_ZEXT: hiNext = '0;
      SRC_SEXT: hiNext = {HI_W{instr[IMM_LO_W-1]}};
      default:  hiNext = instr[HI_W-1:0];
    endcase
    loNext = strobe.loImm ? instr[IMM_LO_W-1:0] : bRegVal[IMM_LO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aOperand  <= '0;
      bOperand  <= '0;
      storeData <= '0;
    end else begin
      if (strobe.loadA)  aOperand <= fwdVal;
      if (strobe.loadHi) bOperand[DATA_W-1:IMM_LO_W] <= hiNext;
      if (strobe.loadLo) bOperand[IMM_LO_W-1:0] <= loNext;
      if (strobe.loadSt) storeData <= bRegVal;
    end
  end
endmodule

// File: rtl/operand_select_stage.sv
module operand_select_stage
  import opsel_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IMM_LO_W = 4,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stageEn,
  input  logic [DATA_W-1:0] instr,
  input  logic [1:0]        bSel,
  input  logic              isStore,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  prevDestIdx,
  input  logic              prevWrites,
  input  logic [DATA_W-1:0] aRegVal,
  input  logic [DATA_W-1:0] bRegVal,
  input  logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] aOperand,
  output logic [DATA_W-1:0] bOperand,
  output logic [DATA_W-1:0] storeData,
  output logic              prefixPending
);
  strobeT strobe;

  opsel_ctrl #(.IDX_W(IDX_W)) ctrl (
    .clk(clk), .rst(rst), .stageEn(stageEn), .bSel(bSel), .isStore(isStore),
    .srcAIdx(srcAIdx), .prevDestIdx(prevDestIdx), .prevWrites(prevWrites),
    .strobe(strobe), .pending(prefixPending)
  );

  opsel_datapath #(.DATA_W(DATA_W), .IMM_LO_W(IMM_LO_W)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .instr(instr),
    .aRegVal(aRegVal), .bRegVal(bRegVal), .aluResult(aluResult),
    .aOperand(aOperand), .bOperand(bOperand), .storeData(storeData)
  );
endmodule

// File: rtl/operand_select_checker.sv
module operand_select_checker #(
  parameter int DATA_W   = 16,
  parameter int IMM_LO_W = 4,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stageEn,
  input logic [DATA_W-1:0] instr,
  input logic [1:0]        bSel,
  input logic              isStore,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [IDX_W-1:0]  prevDestIdx,
  input logic              prevWrites,
  input logic [DATA_W-1:0] aRegVal,
  input logic [DATA_W-1:0] bRegVal,
  input logic [DATA_W-1:0] aluResult,
  input logic [DATA_W-1:0] aOperand,
  input logic [DATA_W-1:0] bOperand,
  input logic [DATA_W-1:0] storeData,
  input logic              prefixPending
);
  localparam int HI_W = DATA_W - IMM_LO_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (aOperand == '0 && bOperand == '0 && storeData == '0 && !prefixPending));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stageEn |=> ($stable(aOperand) && $stable(bOperand) && $stable(storeData)
                  && $stable(prefixPending)));

  assert_forward_R4: assert property (@(posedge clk) disable iff (rst)
    (stageEn && bSel != 2'd3 && prevWrites && prevDestIdx == srcAIdx)
      |=> aOperand == $past(aluResult));

  assert_prefix_load_R7: assert property (@(posedge clk) disable iff (rst)
    (stageEn && bSel == 2'd3)
      |=> (bOperand[DATA_W-1:IMM_LO_W] == $past(instr[HI_W-1:0]) && prefixPending
           && $stable(aOperand) && $stable(bOperand[IMM_LO_W-1:0])));

  assert_prefix_join_R8: assert property (@(posedge clk) disable iff (rst)
    (stageEn && prefixPending && bSel != 2'd3)
      |=> ($stable(bOperand[DATA_W-1:IMM_LO_W])
           && bOperand[IMM_LO_W-1:0] == $past(instr[IMM_LO_W-1:0]) && !prefixPending));

  assert_store_R9: assert property (@(posedge clk) disable iff (rst)
    (stageEn && isStore) |=> storeData == $past(bRegVal));
endmodule

bind operand_select_stage operand_select_checker #(
  .DATA_W(DATA_W), .IMM_LO_W(IMM_LO_W), .IDX_W(IDX_W)
) chk (
  .clk(clk), .rst(rst), .stageEn(stageEn), .instr(instr), .bSel(bSel),
  .isStore(isStore), .srcAIdx(srcAIdx), .prevDestIdx(prevDestIdx),
  .prevWrites(prevWrites), .aRegVal(aRegVal), .bRegVal(bRegVal),
  .aluResult(aluResult), .aOperand(aOperand), .bOperand(bOperand),
  .storeData(storeData), .prefixPending(prefixPending)
);

// File: tb/operand_select_stage_test.sv
module operand_select_stage_test;
  logic        clk = 1'b0;
  logic        rst, stageEn, isStore, prevWrites;
  logic [15:0] instr, aRegVal, bRegVal, aluResult;
  logic [1:0]  bSel;
  logic [3:0]  srcAIdx, prevDestIdx;
  logic [15:0] aOperand, bOperand, storeData;
  logic        prefixPending;

  int checks = 0, failures = 0;
  logic [15:0] expA, expB, expSt;
  logic        expP;
  bit          done = 0;

  always #2.5 clk = ~clk;

  operand_select_stage uut (
    .clk(clk), .rst(rst), .stageEn(stageEn), .instr(instr), .bSel(bSel),
    .isStore(isStore), .srcAIdx(srcAIdx), .prevDestIdx(prevDestIdx),
    .prevWrites(prevWrites), .aRegVal(aRegVal), .bRegVal(bRegVal),
    .aluResult(aluResult), .aOperand(aOperand), .bOperand(bOperand),
    .storeData(storeData), .prefixPending(prefixPending)
  );

  function automatic logic [15:0] bNext(logic [15:0] cur, logic pend, logic [1:0] s,
                                        logic [15:0] ir, logic [15:0] br);
    if (s == 2'd3)  return {ir[11:0], cur[3:0]};
    if (pend)       return {cur[15:4], ir[3:0]};
    case (s)
      2'd0:    return br;
      2'd1:    return {12'h000, ir[3:0]};
      default: return {{12{ir[3]}}, ir[3:0]};
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // apply one cycle of inputs, update model, compare after the edge
  task automatic step(string tag, bit r, bit en, logic [1:0] s, logic [15:0] ir,
                      logic [15:0] ar, logic [15:0] br, logic [15:0] alu,
                      logic [3:0] sa, logic [3:0] pd, bit pw, bit st);
    @(negedge clk);
    rst = r; stageEn = en; bSel = s; instr = ir; aRegVal = ar; bRegVal = br;
    aluResult = alu; srcAIdx = sa; prevDestIdx = pd; prevWrites = pw; isStore = st;
    if (r) begin
      expA = 0; expB = 0; expSt = 0; expP = 0;
    end else if (en) begin
      if (s != 2'd3) expA = (pw && pd == sa) ? alu : ar;
      expB = bNext(expB, expP, s, ir, br);
      if (st) expSt = br;
      expP = (s == 2'd3);
    end
    @(posedge clk); #1;
    check({tag, " aOperand"}, aOperand, expA);
    check({tag, " bOperand"}, bOperand, expB);
    check({tag, " storeData"}, storeData, expSt);
    check({tag, " prefixPending"}, {15'd0, prefixPending}, {15'd0, expP});
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    expA = 0; expB = 0; expSt = 0; expP = 0;
    step("R1 reset", 1, 0, 0, 16'hFFFF, 16'h1111, 16'h2222, 16'h3333, 0, 0, 0, 0);
    step("R1 reset", 1, 1, 3, 16'hFFFF, 16'h1111, 16'h2222, 16'h3333, 0, 0, 1, 1);
    step("R3 R5 reg", 0, 1, 0, 16'h0000, 16'hA5A5, 16'h5A5A, 16'hDEAD, 1, 2, 1, 0);
    step("R6 zext", 0, 1, 1, 16'hFFFE, 16'h1234, 16'h9999, 16'h0, 1, 2, 1, 0);
    step("R6 sext neg", 0, 1, 2, 16'h000B, 16'h1234, 16'h9999, 16'h0, 1, 2, 1, 0);
    step("R6 sext pos", 0, 1, 2, 16'hFFF5, 16'h1234, 16'h9999, 16'h0, 1, 2, 1, 0);
    step("R4 fwd add1", 0, 1, 0, 16'h0, 16'h0101, 16'h0202, 16'hBEEF, 3, 3, 1, 0);
    step("R4 fwd add2", 0, 1, 0, 16'h0, 16'h0303, 16'h0404, 16'hCAFE, 5, 5, 1, 0);
    step("R4 no write", 0, 1, 0, 16'h0, 16'h0505, 16'h0606, 16'hF00D, 5, 5, 0, 0);
    step("R9 store", 0, 1, 1, 16'h0007, 16'h0, 16'h7777, 16'h0, 0, 1, 0, 1);
    step("R9 no store", 0, 1, 1, 16'h0007, 16'h0, 16'h8888, 16'h0, 0, 1, 0, 0);
    step("R7 prefix", 0, 1, 3, 16'hF123, 16'h4444, 16'h0, 16'h5555, 2, 2, 1, 0);
    step("R8 addi join", 0, 1, 2, 16'h000C, 16'h0010, 16'h0, 16'h0, 2, 3, 1, 0);
    step("R7 prefix2", 0, 1, 3, 16'h0ABC, 16'h0, 16'h0, 16'h0, 0, 1, 0, 0);
    step("R2 stall mid", 0, 0, 0, 16'h0FFF, 16'h6666, 16'hEEEE, 16'h0, 0, 1, 0, 1);
    step("R2 stall mid", 0, 0, 2, 16'h0FFF, 16'h6666, 16'hEEEE, 16'h0, 0, 1, 0, 1);
    step("R8 join reg", 0, 1, 0, 16'h0009, 16'h0020, 16'hFFFF, 16'h0, 0, 1, 0, 0);
    step("R7 prefix3", 0, 1, 3, 16'h0111, 16'h0, 16'h0, 16'h0, 0, 1, 0, 0);
    step("R7 prefix again", 0, 1, 3, 16'h0222, 16'h0, 16'h0, 16'h0, 0, 1, 0, 0);
    step("R8 join zext", 0, 1, 1, 16'h0003, 16'h0, 16'h0, 16'h0, 0, 1, 0, 0);
    for (int i = 0; i < 2000; i++) begin
      step("random", ($urandom % 97) == 0, ($urandom % 5) != 0, 2'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           4'($urandom % 3), 4'($urandom % 3), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule